// File: doc/BRIEF.md
# SPI FIFO Status and Request Router

This block keeps the bookkeeping state of an SPI controller's transmit and receive FIFOs without holding any of their data. It keeps a fill count and a read pointer for each FIFO. It moves them only on transfer events: a push write, a frame moving into the shift register, the last receive bit being sampled, and a pop read. From this state it derives six status flags.

A select-and-enable register decides which flags may raise a request. For the transmit-room flag and the receive-data flag, it also steers the request either to a DMA request line or to the shared interrupt line. The other four flags can only raise the interrupt. Software clears the sticky flags by writing ones to the status word. The receive-data flag can also be cleared by a DMA acknowledge once the receive FIFO has drained. The select-and-enable register is frozen while the controller is running.

Top module: `spi_fifo_status_router`

## Requirements
- R1: After reset, both counts and both pointers are 0, the select-and-enable register reads 0, the status word reads 0x0004 (only transmit-room set), and irq and both DMA requests are low.
- R2: The select-and-enable register (reg_addr=0) uses MSB-first numbering, so bit n is reg_wdata[15-n]. The active bits are n=0 (transfer-done enable), 3 (queue-end enable), 4 (tx-underflow enable), 6 (tx-room enable), 7 (tx-room DMA select), 12 (rx-overflow enable), 14 (rx-data enable) and 15 (rx-data DMA select). All other bits read 0, so writing 0xFFFF reads back 0x9B0B.
- R3: A write to the select-and-enable register while running is high leaves it unchanged.
- R4: tx_push increments tx_count. A push at a count of 4 is dropped and the count does not change.
- R5: tx_to_shift with tx_count>0 decrements tx_count and advances tx_next_ptr modulo 4. With tx_count=0 it sets the tx-underflow flag and changes neither the count nor the pointer.
- R6: rx_frame_done increments rx_count and sets the transfer-done flag. At rx_count=4 it instead sets the rx-overflow flag and leaves the count unchanged.
- R7: rx_pop with rx_count>0 decrements rx_count and advances pop_next_ptr modulo 4. A pop on an empty FIFO changes nothing.
- R8: The rx-data flag is set in the cycle after any cycle with rx_count>0. A status write-one or a dma_ack clears it only while rx_count is 0; otherwise it stays set.
- R9: The tx-room flag is high exactly while tx_count<4.
- R10: The queue-end flag is set when a tx_to_shift takes the last transmit entry (count 1 to 0).
- R11: The status word (reg_addr=1) has flag bits [5] transfer-done, [4] queue-end, [3] tx-underflow, [2] tx-room, [1] rx-overflow, [0] rx-data. Writing 1 to a bit clears that sticky flag, a same-cycle set wins, and the write has no effect on tx-room.
- R12: dma_tx_req is tx-room AND its enable AND its select. dma_rx_req is rx-data AND its enable AND its select. irq is the OR of all enabled flags whose select is 0 (the four flags without a select always route to irq).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| running | input | 1 | Controller is running; locks the select-and-enable register |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = select-and-enable register, 1 = status word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| tx_push | input | 1 | Push write into transmit FIFO |
| tx_to_shift | input | 1 | Transmit entry moved to shift register |
| rx_frame_done | input | 1 | Last receive bit of a frame sampled |
| rx_pop | input | 1 | Pop read from receive FIFO |
| dma_ack | input | 1 | DMA acknowledge for receive drain |
| tx_count | output | 4 | Transmit entries held |
| tx_next_ptr | output | 4 | Transmit entry sent next |
| rx_count | output | 4 | Receive entries held |
| pop_next_ptr | output | 4 | Receive entry returned by next pop |
| flags | output | 6 | Status flags, layout as in R11 |
| dma_tx_req | output | 1 | Transmit-room DMA request |
| dma_rx_req | output | 1 | Receive-data DMA request |
| irq | output | 1 | Interrupt line |

## Verification
The transmit side is driven through push runs of zero to six and shift runs past empty. This separates saturation, dropped pushes, underflow and the queue-end event. The same runs repeat on the receive side, along with a long interleaved ring of push/shift and frame/pop that shows the pointer wrap apart from the count. Clears of the rx-data flag are tried both while data is held and after the FIFO drains, which shows whether the clear is gated by emptiness. The routing is swept over all enable and select combinations for flags that are set, so that a DMA-steered flag can be told apart from an interrupt-steered one.

// File: rtl/spi_fsr_pkg.sv
package spi_fsr_pkg;
  localparam int REG_W  = 16;
  localparam int CNT_W  = 4;
  localparam int FLAG_W = 6;

  // status word flag positions
  localparam int FL_RX_DATA   = 0;
  localparam int FL_RX_OVER   = 1;
  localparam int FL_TX_ROOM   = 2;
  localparam int FL_TX_UNDER  = 3;
  localparam int FL_QUEUE_END = 4;
  localparam int FL_XFER_DONE = 5;

  // select-and-enable bit numbers, MSB-first
  localparam int EN_XFER_DONE  = 0;
  localparam int EN_QUEUE_END  = 3;
  localparam int EN_TX_UNDER   = 4;
  localparam int EN_TX_ROOM    = 6;
  localparam int SEL_TX_ROOM   = 7;
  localparam int EN_RX_OVER    = 12;
  localparam int EN_RX_DATA    = 14;
  localparam int SEL_RX_DATA   = 15;

  function automatic int msb_pos(input int n);
    return REG_W - 1 - n;
  endfunction

  function automatic logic [REG_W-1:0] writable_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[msb_pos(EN_XFER_DONE)] = 1'b1;
    m[msb_pos(EN_QUEUE_END)] = 1'b1;
    m[msb_pos(EN_TX_UNDER)]  = 1'b1;
    m[msb_pos(EN_TX_ROOM)]   = 1'b1;
    m[msb_pos(SEL_TX_ROOM)]  = 1'b1;
    m[msb_pos(EN_RX_OVER)]   = 1'b1;
    m[msb_pos(EN_RX_DATA)]   = 1'b1;
    m[msb_pos(SEL_RX_DATA)]  = 1'b1;
    return m;
  endfunction

  function automatic logic [CNT_W-1:0] ptr_step(input logic [CNT_W-1:0] p, input int depth);
    return (int'(p) == depth - 1) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_apply(input logic [CNT_W-1:0] c,
                                                 input logic inc, input logic dec);
    return c + CNT_W'(inc) - CNT_W'(dec);
  endfunction
endpackage

// File: rtl/spi_fsr_tx_track.sv
module spi_fsr_tx_track
  import spi_fsr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             shift,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt_ptr,
  output logic             take_ev,
  output logic             under_ev,
  output logic             drain_ev
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, ptr_q;
  logic             push_ok;

  assign push_ok  = push && (cnt_q < DEPTH_C);
  assign take_ev  = shift && (cnt_q != '0);
  assign under_ev = shift && (cnt_q == '0);
  assign drain_ev = take_ev && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else begin
      cnt_q <= cnt_apply(cnt_q, push_ok, take_ev);
      if (take_ev) ptr_q <= ptr_step(ptr_q, DEPTH);
    end
  end

  assign cnt     = cnt_q;
  assign nxt_ptr = ptr_q;
endmodule

// File: rtl/spi_fsr_rx_track.sv
module spi_fsr_rx_track
  import spi_fsr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic             pop,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] pop_ptr,
  output logic             store_ev,
  output logic             over_ev,
  output logic             pop_ev
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, ptr_q;

  assign store_ev = frame_done && (cnt_q < DEPTH_C);
  assign over_ev  = frame_done && (cnt_q >= DEPTH_C);
  assign pop_ev   = pop && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else begin
      cnt_q <= cnt_apply(cnt_q, store_ev, pop_ev);
      if (pop_ev) ptr_q <= ptr_step(ptr_q, DEPTH);
    end
  end

  assign cnt     = cnt_q;
  assign pop_ptr = ptr_q;
endmodule

// File: rtl/spi_fsr_router.sv
module spi_fsr_router
  import spi_fsr_pkg::*;
(
  input  logic [FLAG_W-1:0] flag,
  input  logic [FLAG_W-1:0] flag_en,
  input  logic [FLAG_W-1:0] flag_dma,
  output logic [FLAG_W-1:0] irq_src,
  output logic              dma_tx,
  output logic              dma_rx,
  output logic              irq
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_route
    assign irq_src[i] = flag[i] & flag_en[i] & ~flag_dma[i];
  end

  assign irq    = |irq_src;
  assign dma_tx = flag[FL_TX_ROOM] & flag_en[FL_TX_ROOM] & flag_dma[FL_TX_ROOM];
  assign dma_rx = flag[FL_RX_DATA] & flag_en[FL_RX_DATA] & flag_dma[FL_RX_DATA];
endmodule

// File: rtl/spi_fifo_status_router.sv
module spi_fifo_status_router
  import spi_fsr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        running,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        tx_push,
  input  logic        tx_to_shift,
  input  logic        rx_frame_done,
  input  logic        rx_pop,
  input  logic        dma_ack,
  output logic [3:0]  tx_count,
  output logic [3:0]  tx_next_ptr,
  output logic [3:0]  rx_count,
  output logic [3:0]  pop_next_ptr,
  output logic [5:0]  flags,
  output logic        dma_tx_req,
  output logic        dma_rx_req,
  output logic        irq
);
  localparam logic [REG_W-1:0] EN_MASK = writable_mask();
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [REG_W-1:0]  en_q;
  logic              en_wr, stat_wr;
  logic [FLAG_W-1:0] w1c, sticky_set, sticky_q, flag_vec;
  logic [FLAG_W-1:0] flag_en, flag_dma, irq_src;
  logic              tx_take_ev, tx_under_ev, tx_drain_ev;
  logic              rx_store_ev, rx_over_ev, rx_pop_ev;
  logic [CNT_W-1:0]  tx_cnt, tx_ptr, rx_cnt, rx_ptr;

  assign en_wr   = reg_wr && !reg_addr && !running;
  assign stat_wr = reg_wr && reg_addr;
  assign w1c     = stat_wr ? reg_wdata[FLAG_W-1:0] : '0;

  spi_fsr_tx_track #(.DEPTH(DEPTH)) tx_i (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .shift(tx_to_shift),
    .cnt(tx_cnt), .nxt_ptr(tx_ptr),
    .take_ev(tx_take_ev), .under_ev(tx_under_ev), .drain_ev(tx_drain_ev)
  );

  spi_fsr_rx_track #(.DEPTH(DEPTH)) rx_i (
    .clk(clk), .rst_n(rst_n), .frame_done(rx_frame_done), .pop(rx_pop),
    .cnt(rx_cnt), .pop_ptr(rx_ptr),
    .store_ev(rx_store_ev), .over_ev(rx_over_ev), .pop_ev(rx_pop_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= reg_wdata & EN_MASK;
  end

  // set sources for sticky flags; tx-room is a level, not sticky
  always_comb begin
    sticky_set               = '0;
    sticky_set[FL_XFER_DONE] = rx_frame_done;
    sticky_set[FL_QUEUE_END] = tx_drain_ev;
    sticky_set[FL_TX_UNDER]  = tx_under_ev;
    sticky_set[FL_RX_OVER]   = rx_over_ev;
    sticky_set[FL_RX_DATA]   = (rx_cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
    end else begin
      for (int i = 0; i < FLAG_W; i++) begin
        if (i == FL_RX_DATA)
          sticky_q[i] <= sticky_set[i] | (sticky_q[i] & ~(w1c[i] | dma_ack));
        else if (i != FL_TX_ROOM)
          sticky_q[i] <= sticky_set[i] | (sticky_q[i] & ~w1c[i]);
        else
          sticky_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    flag_vec             = sticky_q;
    flag_vec[FL_TX_ROOM] = (tx_cnt < DEPTH_C);
  end

  always_comb begin
    flag_en                = '0;
    flag_dma               = '0;
    flag_en[FL_XFER_DONE]  = en_q[msb_pos(EN_XFER_DONE)];
    flag_en[FL_QUEUE_END]  = en_q[msb_pos(EN_QUEUE_END)];
    flag_en[FL_TX_UNDER]   = en_q[msb_pos(EN_TX_UNDER)];
    flag_en[FL_TX_ROOM]    = en_q[msb_pos(EN_TX_ROOM)];
    flag_en[FL_RX_OVER]    = en_q[msb_pos(EN_RX_OVER)];
    flag_en[FL_RX_DATA]    = en_q[msb_pos(EN_RX_DATA)];
    flag_dma[FL_TX_ROOM]   = en_q[msb_pos(SEL_TX_ROOM)];
    flag_dma[FL_RX_DATA]   = en_q[msb_pos(SEL_RX_DATA)];
  end

  spi_fsr_router route_i (
    .flag(flag_vec), .flag_en(flag_en), .flag_dma(flag_dma),
    .irq_src(irq_src), .dma_tx(dma_tx_req), .dma_rx(dma_rx_req), .irq(irq)
  );

  assign reg_rdata    = reg_addr ? {{(REG_W-FLAG_W){1'b0}}, flag_vec} : en_q;
  assign flags        = flag_vec;
  assign tx_count     = tx_cnt;
  assign tx_next_ptr  = tx_ptr;
  assign rx_count     = rx_cnt;
  assign pop_next_ptr = rx_ptr;
endmodule

// File: rtl/spi_fsr_checker.sv
module spi_fsr_checker
  import spi_fsr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              running,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic              tx_push,
  input logic              tx_to_shift,
  input logic              rx_frame_done,
  input logic              rx_pop,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  tx_next_ptr,
  input logic [CNT_W-1:0]  rx_count,
  input logic [FLAG_W-1:0] flags,
  input logic [REG_W-1:0]  en_q,
  input logic              tx_under_ev,
  input logic              rx_over_ev,
  input logic              dma_tx_req,
  input logic              dma_rx_req
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  AST_TX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= DEPTH_C); // R4
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && !tx_to_shift && tx_count == DEPTH_C) |=> (tx_count == DEPTH_C)); // R4
  AST_TX_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_to_shift && tx_count != '0) |=>
      (tx_next_ptr == ptr_step($past(tx_next_ptr), DEPTH))); // R5
  AST_UNDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_under_ev |=> flags[FL_TX_UNDER]); // R5
  AST_RX_OVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_over_ev && !rx_pop) |=> (rx_count == DEPTH_C && flags[FL_RX_OVER])); // R6
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_frame_done && rx_count == '0) |=> (rx_count == '0)); // R7
  AST_RX_DATA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count != '0) |=> flags[FL_RX_DATA]); // R8
  AST_EN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (running && reg_wr && !reg_addr) |=> $stable(en_q)); // R3
  AST_TX_ROOM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FL_TX_ROOM] == (tx_count < DEPTH_C)); // R9
  AST_DMA_TX_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> flags[FL_TX_ROOM]); // R12
  AST_DMA_RX_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> flags[FL_RX_DATA]); // R12
endmodule

bind spi_fifo_status_router spi_fsr_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .running(running), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .tx_push(tx_push), .tx_to_shift(tx_to_shift), .rx_frame_done(rx_frame_done),
  .rx_pop(rx_pop), .tx_count(tx_count), .tx_next_ptr(tx_next_ptr),
  .rx_count(rx_count), .flags(flags), .en_q(en_q), .tx_under_ev(tx_under_ev),
  .rx_over_ev(rx_over_ev), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
);

// File: tb/spi_fifo_status_router_tb.sv
module spi_fifo_status_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        running = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tx_push = 1'b0, tx_to_shift = 1'b0, rx_frame_done = 1'b0;
  logic        rx_pop = 1'b0, dma_ack = 1'b0;
  logic [3:0]  tx_count, tx_next_ptr, rx_count, pop_next_ptr;
  logic [5:0]  flags;
  logic        dma_tx_req, dma_rx_req, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_fifo_status_router dut_i (
    .clk(clk), .rst_n(rst_n), .running(running), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_push(tx_push), .tx_to_shift(tx_to_shift), .rx_frame_done(rx_frame_done),
    .rx_pop(rx_pop), .dma_ack(dma_ack), .tx_count(tx_count),
    .tx_next_ptr(tx_next_ptr), .rx_count(rx_count), .pop_next_ptr(pop_next_ptr),
    .flags(flags), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq(irq)
  );

  function automatic logic [15:0] ebit(input int n);
    return 16'h1 << (15 - n);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one clock with the given strobes; returns at the following negedge
  task automatic step(input logic p, input logic s, input logic f, input logic o,
                      input logic a);
    tx_push = p; tx_to_shift = s; rx_frame_done = f; rx_pop = o; dma_ack = a;
    @(posedge clk); @(negedge clk);
    tx_push = 0; tx_to_shift = 0; rx_frame_done = 0; rx_pop = 0; dma_ack = 0;
  endtask

  task automatic wr(input logic addr, input logic [15:0] d);
    reg_wr = 1; reg_addr = addr; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic addr, output logic [15:0] d);
    reg_addr = addr; #1; d = reg_rdata;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int ec, ep;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_count", 16'(tx_count), 0);
    chk("R1 ptrs", 16'({tx_next_ptr, pop_next_ptr}), 0);
    chk("R1 rx_count", 16'(rx_count), 0);
    rd(0, d); chk("R1 enable reg", d, 0);
    rd(1, d); chk("R1 status", d, 16'h0004);
    chk("R1 requests", 16'({irq, dma_tx_req, dma_rx_req}), 0);

    // R2 writable bits
    wr(0, 16'hFFFF); rd(0, d); chk("R2 mask", d, 16'h9B0B);
    wr(0, ebit(6) | ebit(15)); rd(0, d); chk("R2 bit order", d, 16'h0201);
    // R3 lock while running
    running = 1; wr(0, 16'h0000); rd(0, d); chk("R3 locked", d, 16'h0201);
    running = 0; wr(0, 16'h0000); rd(0, d); chk("R3 unlocked", d, 16'h0000);

    // R4/R9 push sweep
    for (int k = 1; k <= 6; k++) begin
      step(1, 0, 0, 0, 0);
      ec = (k > 4) ? 4 : k;
      chk("R4 push count", 16'(tx_count), 16'(ec));
      chk("R9 tx room", 16'(flags[2]), 16'(ec < 4));
    end
    // R5/R10 shift sweep past empty
    for (int k = 1; k <= 6; k++) begin
      step(0, 1, 0, 0, 0);
      ec = (k > 4) ? 0 : 4 - k;
      ep = (k > 4) ? 0 : k % 4;
      chk("R5 shift count", 16'(tx_count), 16'(ec));
      chk("R5 next ptr", 16'(tx_next_ptr), 16'(ep));
      if (k == 4) chk("R10 queue end", 16'(flags[4]), 1);
      if (k == 4) chk("R5 no underflow yet", 16'(flags[3]), 0);
    end
    chk("R5 underflow", 16'(flags[3]), 1);
    // R11 clear sticky tx flags; tx-room unaffected
    wr(1, 16'h003F); rd(1, d); chk("R11 w1c", d, 16'h0004);
    // R11 set wins over clear
    reg_wr = 1; reg_addr = 1; reg_wdata = 16'h0008;
    step(0, 1, 0, 0, 0); reg_wr = 0;
    chk("R11 set wins", 16'(flags[3]), 1);
    wr(1, 16'h0008);

    // R5 pointer ring: push then shift, many laps
    for (int k = 1; k <= 10; k++) begin
      step(1, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      chk("R5 ring ptr", 16'(tx_next_ptr), 16'(k % 4));
      chk("R5 ring count", 16'(tx_count), 0);
    end
    // R4 push and shift same cycle keep count
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    chk("R4 push+shift", 16'(tx_count), 1);
    step(0, 1, 0, 0, 0);
    wr(1, 16'h003F);

    // R6 frame sweep
    for (int k = 1; k <= 5; k++) begin
      step(0, 0, 1, 0, 0);
      ec = (k > 4) ? 4 : k;
      chk("R6 rx count", 16'(rx_count), 16'(ec));
      chk("R6 xfer done", 16'(flags[5]), 1);
      chk("R6 overflow", 16'(flags[1]), 16'(k > 4));
    end
    step(0, 0, 0, 0, 0);
    chk("R8 rx data set", 16'(flags[0]), 1);
    wr(1, 16'h0001);
    chk("R8 w1c ignored nonempty", 16'(flags[0]), 1);
    step(0, 0, 0, 0, 1);
    chk("R8 ack ignored nonempty", 16'(flags[0]), 1);
    // R7 pop sweep past empty
    for (int k = 1; k <= 6; k++) begin
      step(0, 0, 0, 1, 0);
      ec = (k > 4) ? 0 : 4 - k;
      ep = (k > 4) ? 0 : k % 4;
      chk("R7 rx count", 16'(rx_count), 16'(ec));
      chk("R7 pop ptr", 16'(pop_next_ptr), 16'(ep));
    end
    chk("R8 held after drain", 16'(flags[0]), 1);
    step(0, 0, 0, 0, 1);
    chk("R8 ack clears empty", 16'(flags[0]), 0);
    step(0, 0, 1, 0, 0); step(0, 0, 0, 1, 0); step(0, 0, 0, 0, 0);
    chk("R7 ptr after one", 16'(pop_next_ptr), 1);
    chk("R8 set again", 16'(flags[0]), 1);
    wr(1, 16'h0001);
    chk("R8 w1c clears empty", 16'(flags[0]), 0);
    wr(1, 16'h003F);

    // R12 routing: rx-data set, tx-room set
    step(0, 0, 1, 0, 0); step(0, 0, 0, 0, 0);
    wr(1, 16'h0020);  // drop transfer-done so only rx-data and tx-room are up
    for (int m = 0; m < 16; m++) begin
      d = (m[0] ? ebit(14) : 16'h0) | (m[1] ? ebit(15) : 16'h0) |
          (m[2] ? ebit(6) : 16'h0)  | (m[3] ? ebit(7) : 16'h0);
      wr(0, d);
      chk("R12 dma_rx", 16'(dma_rx_req), 16'(m[0] & m[1]));
      chk("R12 dma_tx", 16'(dma_tx_req), 16'(m[2] & m[3]));
      chk("R12 irq", 16'(irq), 16'((m[0] & ~m[1]) | (m[2] & ~m[3])));
    end
    // R12 non-steerable flag goes to irq, DMA select bits irrelevant
    wr(0, ebit(0) | ebit(7) | ebit(15));
    chk("R12 irq quiet", 16'(irq), 0);
    step(0, 0, 0, 1, 0); step(0, 0, 1, 0, 0);
    chk("R12 xfer irq", 16'(irq), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule